// File: doc/BRIEF.md
# SHA-512 Paired Message Schedule Generator

This block expands one 1024-bit message block into the 80-word SHA-512 message schedule and hands the words out two at a time, as a 128-bit pair. A start strobe captures the block into a rolling window of eight word pairs. Each accepted advance strobe then shifts the oldest pair out to the output, while a new pair is formed from the window and pushed in at the young end.

The first eight pairs emitted are the block's own sixteen words. The remaining thirty-two pairs are generated by the SHA-512 expansion recurrence. Each generated word first sums the oldest term with its sigma_0 term, and then adds the w[t-7] term and the sigma_1 term. The w[t-7] lane pair is not aligned with the stored pairs. It is formed by joining the high word of one stored pair to the low word of the next. A compression core drives one advance per pair of rounds and reads the pair on the cycle after the valid flag rises.

Top module: `msg_pair_sched`

## Requirements
- R1: After reset, sched_valid is 0 and sched_pair is 0. Advance strobes have no effect until the first start.
- R2: The input block is read big-endian. Byte 0 sits in blk_data[1023:1016] and is the most significant byte of word 0, and word k is blk_data[1023-64k -: 64]. Pair n carries word 2n in sched_pair[63:0] and word 2n+1 in sched_pair[127:64]. Pairs 0 to 7 are the block words 0 to 15 unchanged.
- R3: Pairs 8 to 39 carry words w[t] = w[t-16] + sigma_0(w[t-15]) + w[t-7] + sigma_1(w[t-2]), with all additions modulo 2^64.
- R4: sigma_0(x) = ror(x,1) ^ ror(x,8) ^ (x>>7), and sigma_1(x) = ror(x,19) ^ ror(x,61) ^ (x>>6), where ror is a 64-bit rotate right and >> is a logical shift.
- R5: An accepted advance raises sched_valid for exactly the next cycle, with the new pair on sched_pair. Otherwise sched_valid is 0 and sched_pair holds its value.
- R6: Once all 40 pairs have been produced, advance strobes are ignored until the next start: no valid pulse appears and sched_pair is unchanged.
- R7: A start restarts the schedule from pair 0 of the newly captured block, even in the middle of a schedule. A start wins over an advance in the same cycle, and that advance produces no output.
- R8: Advances in consecutive cycles produce consecutive pairs, one pair per cycle, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture blk_data and restart the schedule |
| blk_data | input | 1024 | Message block, byte 0 in the top bits |
| adv | input | 1 | Request the next schedule pair |
| sched_pair | output | 128 | Word 2n in the low half, word 2n+1 in the high half |
| sched_valid | output | 1 | sched_pair was updated by the previous advance |

## Verification
The assertions assume that blk_data is stable only in the cycle start is high, and that start and adv are plain synchronous strobes that may be high in any cycle, including together. They make no assumption about the spacing of advances. The stimulus keeps to these rules: it changes inputs only away from the rising edge, and it drives gapless bursts, spaced advances, surplus advances past the last pair, a start that collides with an advance, and a start that aborts a schedule halfway. The bench's own model recomputes the full 80-word schedule from the block and compares both outputs on every clock.

// File: rtl/msg_pair_sched.sv
module msg_pair_sched #(
  parameter int WORD_W      = 64,
  parameter int WIN         = 8,
  parameter int TOTAL_PAIRS = 40
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [2*WORD_W*WIN-1:0]   blk_data,
  input  logic                      adv,
  output logic [2*WORD_W-1:0]       sched_pair,
  output logic                      sched_valid
);
  localparam int PAIR_W = 2 * WORD_W;
  localparam int BLK_W  = PAIR_W * WIN;
  localparam int CNT_W  = $clog2(TOTAL_PAIRS + 1);
  localparam int TAP_A  = 0;
  localparam int TAP_B  = 1;
  localparam int TAP_C  = WIN - 4;
  localparam int TAP_D  = WIN - 3;
  localparam int TAP_E  = WIN - 1;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] sig_lo(input logic [WORD_W-1:0] x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [WORD_W-1:0] sig_hi(input logic [WORD_W-1:0] x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  logic [PAIR_W-1:0] win [WIN];
  logic [CNT_W-1:0]  cnt;
  logic              done, take;
  logic [PAIR_W-1:0] far_pair, spliced, stage0, fresh;

  assign done = (cnt == CNT_W'(TOTAL_PAIRS));
  assign take = adv && !start && !done;

  // w[t-15] lanes: high word of the oldest pair, low word of the next
  assign far_pair = {win[TAP_B][WORD_W-1:0], win[TAP_A][PAIR_W-1:WORD_W]};
  // w[t-7] lanes: high word of pair n-4, low word of pair n-3
  assign spliced  = {win[TAP_D][WORD_W-1:0], win[TAP_C][PAIR_W-1:WORD_W]};

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    assign stage0[ln*WORD_W +: WORD_W] = win[TAP_A][ln*WORD_W +: WORD_W]
                                       + sig_lo(far_pair[ln*WORD_W +: WORD_W]);
    assign fresh[ln*WORD_W +: WORD_W]  = stage0[ln*WORD_W +: WORD_W]
                                       + spliced[ln*WORD_W +: WORD_W]
                                       + sig_hi(win[TAP_E][ln*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) win[i] <= '0;
      cnt <= CNT_W'(TOTAL_PAIRS);
    end else if (start) begin
      for (int i = 0; i < WIN; i++)
        win[i] <= {blk_data[BLK_W-1-(2*i+1)*WORD_W -: WORD_W],
                   blk_data[BLK_W-1-(2*i)*WORD_W -: WORD_W]};
      cnt <= '0;
    end else if (take) begin
      for (int i = 0; i < WIN-1; i++) win[i] <= win[i+1];
      win[WIN-1] <= fresh;
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sched_pair  <= '0;
      sched_valid <= 1'b0;
    end else begin
      sched_valid <= take;
      if (take) sched_pair <= win[TAP_A];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL_PAIRS)); // R6
  AST_VALID_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && !done) |=> sched_valid); // R5
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv || start) |=> (!sched_valid && $stable(sched_pair))); // R5
  AST_IGNORE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!sched_valid && $stable(cnt) && $stable(sched_pair))); // R6
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0 && !sched_valid)); // R7
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !start && !done) |=> (cnt == $past(cnt) + 1'b1)); // R8
endmodule

// File: tb/test_msg_pair_sched.sv
module test_msg_pair_sched;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1023:0] blk_data = '0;
  logic          adv = 1'b0;
  logic [127:0]  sched_pair;
  logic          sched_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  msg_pair_sched i_msg_pair_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_data(blk_data),
    .adv(adv), .sched_pair(sched_pair), .sched_valid(sched_valid));

  function automatic longint unsigned rr(longint unsigned x, int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction
  function automatic longint unsigned s0f(longint unsigned x); // R4
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction
  function automatic longint unsigned s1f(longint unsigned x); // R4
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction

  longint unsigned w [80];
  int              m_cnt = 40;
  logic            m_valid = 1'b0;
  logic [127:0]    m_pair = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 40; m_valid = 1'b0; m_pair = '0;
    end else if (start) begin
      for (int k = 0; k < 16; k++) begin
        longint unsigned acc = 0;
        for (int b = 0; b < 8; b++) acc = (acc << 8) | 64'(blk_data[1023 - 8*(8*k+b) -: 8]);
        w[k] = acc;
      end
      for (int t = 16; t < 80; t++)
        w[t] = w[t-16] + s0f(w[t-15]) + w[t-7] + s1f(w[t-2]);
      m_cnt = 0; m_valid = 1'b0;
    end else if (adv && m_cnt < 40) begin
      m_pair = {w[2*m_cnt+1], w[2*m_cnt]};
      m_valid = 1'b1;
      m_cnt++;
    end else begin
      m_valid = 1'b0;
    end
  end

  always @(negedge clk) begin
    string tag;
    cycles++;
    if (!rst_n) tag = "R1";
    else if (m_cnt == 40 && !m_valid) tag = "R6";
    else if (m_valid && m_cnt <= 8) tag = "R2";
    else if (m_valid) tag = "R3";
    else tag = "R5";
    checks++;
    if (sched_valid !== m_valid) begin
      errors++;
      $display("FAIL %s valid: actual %b expected %b (cycle %0d)", tag, sched_valid, m_valid, cycles);
    end
    checks++;
    if (sched_pair !== m_pair) begin
      errors++;
      $display("FAIL %s pair: actual %h expected %h (cycle %0d)", tag, sched_pair, m_pair, cycles);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic load(logic [1023:0] b, logic with_adv); // R7
    start = 1'b1; blk_data = b; adv = with_adv; tick();
    start = 1'b0; adv = 1'b0; blk_data = '0; tick();
  endtask

  task automatic run(int n, int gap); // R5 R8 R6
    for (int i = 0; i < n; i++) begin
      adv = 1'b1; tick(); adv = 1'b0;
      for (int g = 0; g < gap; g++) tick();
    end
    tick();
  endtask

  initial begin
    logic [1023:0] abc, rnd;
    #1;
    tick(); tick();
    // R1: advances before any start do nothing
    rst_n = 1'b1; tick();
    adv = 1'b1; tick(); tick(); adv = 1'b0; tick();
    // R2 R3 R4 R8: padded three-byte message, gapless
    abc = '0;
    abc[1023:992] = 32'h61626380;
    abc[7:0] = 8'h18;
    load(abc, 1'b0);
    run(44, 0);
    // R6: extra advances after the end, spaced
    run(3, 2);
    // all zero and all one blocks, spaced advances
    load('0, 1'b0); run(42, 1);
    load('1, 1'b0); run(41, 3);
    // R7: start colliding with advance, then abort mid schedule
    for (int k = 0; k < 32; k++) rnd[32*k +: 32] = $urandom;
    load(rnd, 1'b1); run(17, 0);
    for (int k = 0; k < 32; k++) rnd[32*k +: 32] = $urandom;
    load(rnd, 1'b0); run(45, 0);
    // R7: start while done
    load(abc, 1'b0); run(40, 0);
    tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule